// File: doc/BRIEF.md
# Fetch Return Instruction Unpacker

This block turns a returned instruction-fetch line into instruction-buffer entries for one wavefront slot. The line arrives as a stream of 32-bit words, one word per cycle, on a valid/ready interface. Each word carries the slot number it belongs to and a flag that marks the final word of the line. The unpacker reads the length bit of the leading word of each instruction. A 4-byte instruction becomes one entry. An 8-byte instruction joins two consecutive words into one entry. Every entry written is stamped with a sequence number from one counter shared by all slots.

Each slot has its own FIFO. It holds four entries plus one line's worth of words, so a full line always fits behind the four-entry fill threshold. A slot can be marked stale with a drop request. The next line returned for that slot is then swallowed whole, and the mark is cleared. When the final word of a line has been consumed, with or without a drop, the block pulses a completion signal with the slot number, so that the slot's fetch-pending flag can be cleared. Three one-cycle error pulses report the following illegal conditions: an over-full buffer when a line arrives, a drop on a non-empty buffer, and an 8-byte instruction cut off by the end of the line. The issue side reads and pops any slot's head through a selectable read port.

Top module: `fetch_unpack`

## Requirements
- R1: After reset every slot buffer is empty (`rd_count` 0, `rd_valid` 0), no drop is pending, and `done_valid`, `err_occ`, `err_drop` and `err_trunc` are all 0.
- R2: A word whose bit 31 is 0, taken where an instruction starts, writes one entry with `rd_wide` 0, `rd_lo` equal to the word and `rd_hi` 0.
- R3: A word whose bit 31 is 1, taken where an instruction starts and not being the last word of the line, is paired with the next word. Together they write one entry with `rd_wide` 1, `rd_lo` equal to the first word and `rd_hi` equal to the second. The bit 31 value of the second word is not examined.
- R4: Entries carry sequence numbers that start at 0 after reset and rise by exactly one per entry written, counted across all slots in write order.
- R5: If the slot's drop mark is set when the first word of a line is accepted, no word of that line writes an entry and the mark is cleared. The next line for the slot is written normally.
- R6: A drop that takes effect while the slot's buffer holds one or more entries pulses `err_drop` for one cycle. The line is still discarded.
- R7: A line whose first word arrives while the slot's buffer holds more than 4 entries pulses `err_occ` for one cycle. The line is still unpacked.
- R8: A word with bit 31 set that is the last word of its line writes no entry and pulses `err_trunc` for one cycle.
- R9: In the cycle after the last word of a line is accepted, `done_valid` is 1 for one cycle and `done_slot` names the line's slot. This holds for dropped lines as well.
- R10: `rsp_ready` is 0 while the target slot's buffer holds its full 4 + WORDS_PER_LINE entries and the line is not being dropped. No word is lost across the stall.
- R11: Each slot returns its entries in write order. `rd_pop` with `rd_valid` removes the head of slot `rd_slot` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Response word present |
| rsp_ready | output | 1 | Word accepted this cycle when high with rsp_valid |
| rsp_slot | input | SLOT_W | Slot of the line (held constant within a line) |
| rsp_word | input | 32 | Instruction word; bit 31 set starts an 8-byte instruction |
| rsp_last | input | 1 | Final word of the line |
| drop_valid | input | 1 | Mark a slot's next line as stale |
| drop_slot | input | SLOT_W | Slot to mark |
| rd_slot | input | SLOT_W | Slot shown on the read port |
| rd_pop | input | 1 | Remove the head entry of rd_slot |
| rd_valid | output | 1 | rd_slot buffer not empty |
| rd_wide | output | 1 | Head entry is 8 bytes |
| rd_lo | output | 32 | Head entry first word |
| rd_hi | output | 32 | Head entry second word (0 for 4-byte entries) |
| rd_seq | output | 16 | Head entry sequence number |
| rd_count | output | CNT_W | Entries held by rd_slot |
| done_valid | output | 1 | Line finished |
| done_slot | output | SLOT_W | Slot of the finished line |
| err_occ | output | 1 | Line arrived with more than 4 entries buffered |
| err_drop | output | 1 | Drop applied to a non-empty buffer |
| err_trunc | output | 1 | 8-byte instruction cut off by end of line |

## Verification
A stuck half-instruction register would pair the wrong words. The fault shows on `rd_lo`/`rd_hi`/`rd_wide` at the next pop of that slot, and every later entry of the line shifts by one word. A lost or stale drop mark shows as one line too many or too few, visible at once in `rd_count` after the line's completion pulse. A sequence counter that skips or repeats shows at the first pop after the fault. A wrong backpressure decision shows either as a stall that never releases or as `rd_count` stopping short of the expected total.

// File: rtl/fru_pkg.sv
package fru_pkg;
    localparam int WORD_W    = 32;
    localparam int SEQ_W     = 16;
    localparam int LEN_BIT   = 31;
    localparam int OCC_LIMIT = 4;

    typedef struct packed {
        logic              wide;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
        logic [SEQ_W-1:0]  seq;
    } ibuf_entry_t;

    function automatic logic starts_wide(input logic [WORD_W-1:0] w);
        return w[LEN_BIT];
    endfunction
endpackage

// File: rtl/fru_slot_fifo.sv
module fru_slot_fifo
    import fru_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  ibuf_entry_t       push_data,
    input  logic              pop,
    output ibuf_entry_t       head,
    output logic [CNT_W-1:0]  count,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    ibuf_entry_t       mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fru_unpack_seq.sv
module fru_unpack_seq
    import fru_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2,
    parameter int CNT_W     = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             rsp_valid,
    output logic                             rsp_ready,
    input  logic [SLOT_W-1:0]                rsp_slot,
    input  logic [WORD_W-1:0]                rsp_word,
    input  logic                             rsp_last,
    input  logic                             drop_valid,
    input  logic [SLOT_W-1:0]                drop_slot,
    input  logic [NUM_SLOTS-1:0][CNT_W-1:0]  slot_cnt,
    input  logic [NUM_SLOTS-1:0]             slot_full,
    output logic [NUM_SLOTS-1:0]             wr_en,
    output ibuf_entry_t                      wr_data,
    output logic                             in_rsp,
    output logic                             done_valid,
    output logic [SLOT_W-1:0]                done_slot,
    output logic                             err_occ,
    output logic                             err_drop,
    output logic                             err_trunc
);
    logic                  in_rsp_q, dropping_q, have_lo_q;
    logic [SLOT_W-1:0]     cur_q;
    logic [WORD_W-1:0]     lo_q;
    logic [NUM_SLOTS-1:0]  drop_q, drop_nxt;
    logic [SEQ_W-1:0]      seq_q;

    logic [SLOT_W-1:0]     tgt;
    logic                  drop_now, accept, first, keep, is_wide, write, trunc;

    assign in_rsp = in_rsp_q;

    always_comb begin
        tgt       = in_rsp_q ? cur_q : rsp_slot;
        drop_now  = in_rsp_q ? dropping_q : drop_q[rsp_slot];
        rsp_ready = !slot_full[tgt] || drop_now;
        accept    = rsp_valid && rsp_ready;
        first     = accept && !in_rsp_q;
        keep      = accept && !drop_now;
        is_wide   = starts_wide(rsp_word);
        write     = keep && (have_lo_q || !is_wide);
        trunc     = keep && !have_lo_q && is_wide && rsp_last;

        wr_data.wide = have_lo_q;
        wr_data.lo   = have_lo_q ? lo_q : rsp_word;
        wr_data.hi   = have_lo_q ? rsp_word : '0;
        wr_data.seq  = seq_q;
        wr_en        = write ? (NUM_SLOTS'(1) << tgt) : '0;

        drop_nxt = drop_q;
        if (first && drop_now) drop_nxt[tgt] = 1'b0;
        if (drop_valid)        drop_nxt[drop_slot] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_rsp_q   <= 1'b0;
            dropping_q <= 1'b0;
            have_lo_q  <= 1'b0;
            cur_q      <= '0;
            lo_q       <= '0;
            drop_q     <= '0;
            seq_q      <= '0;
            done_valid <= 1'b0;
            done_slot  <= '0;
            err_occ    <= 1'b0;
            err_drop   <= 1'b0;
            err_trunc  <= 1'b0;
        end else begin
            if (accept) begin
                in_rsp_q   <= !rsp_last;
                cur_q      <= tgt;
                dropping_q <= drop_now;
                have_lo_q  <= keep && !have_lo_q && is_wide && !rsp_last;
                if (!have_lo_q) lo_q <= rsp_word;
            end
            if (write) seq_q <= seq_q + 1'b1;
            drop_q     <= drop_nxt;
            done_valid <= accept && rsp_last;
            done_slot  <= tgt;
            err_occ    <= first && (slot_cnt[tgt] > CNT_W'(OCC_LIMIT));
            err_drop   <= first && drop_now && (slot_cnt[tgt] != '0);
            err_trunc  <= trunc;
        end
    end
endmodule

// File: rtl/fetch_unpack.sv
module fetch_unpack
    import fru_pkg::*;
#(
    parameter int  NUM_SLOTS      = 4,
    parameter int  WORDS_PER_LINE = 8,
    localparam int SLOT_W         = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int DEPTH          = OCC_LIMIT + WORDS_PER_LINE,
    localparam int CNT_W          = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [SLOT_W-1:0]  rsp_slot,
    input  logic [31:0]        rsp_word,
    input  logic               rsp_last,
    input  logic               drop_valid,
    input  logic [SLOT_W-1:0]  drop_slot,
    input  logic [SLOT_W-1:0]  rd_slot,
    input  logic               rd_pop,
    output logic               rd_valid,
    output logic               rd_wide,
    output logic [31:0]        rd_lo,
    output logic [31:0]        rd_hi,
    output logic [15:0]        rd_seq,
    output logic [CNT_W-1:0]   rd_count,
    output logic               done_valid,
    output logic [SLOT_W-1:0]  done_slot,
    output logic               err_occ,
    output logic               err_drop,
    output logic               err_trunc
);
    logic [NUM_SLOTS-1:0][CNT_W-1:0] slot_cnt;
    logic [NUM_SLOTS-1:0]            slot_full;
    logic [NUM_SLOTS-1:0]            wr_en;
    logic [NUM_SLOTS-1:0]            pop_en;
    ibuf_entry_t                     wr_data;
    ibuf_entry_t                     heads [NUM_SLOTS];
    ibuf_entry_t                     rd_head;
    logic                            rsp_in_prog;

    fru_unpack_seq #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_slot   (rsp_slot),
        .rsp_word   (rsp_word),
        .rsp_last   (rsp_last),
        .drop_valid (drop_valid),
        .drop_slot  (drop_slot),
        .slot_cnt   (slot_cnt),
        .slot_full  (slot_full),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .in_rsp     (rsp_in_prog),
        .done_valid (done_valid),
        .done_slot  (done_slot),
        .err_occ    (err_occ),
        .err_drop   (err_drop),
        .err_trunc  (err_trunc)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign pop_en[s] = rd_pop && rd_valid && (rd_slot == SLOT_W'(s));
        fru_slot_fifo #(
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
        ) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (wr_en[s]),
            .push_data (wr_data),
            .pop       (pop_en[s]),
            .head      (heads[s]),
            .count     (slot_cnt[s]),
            .full      (slot_full[s])
        );
    end

    always_comb begin
        rd_count = slot_cnt[rd_slot];
        rd_valid = (rd_count != '0);
        rd_head  = heads[rd_slot];
        rd_wide  = rd_head.wide;
        rd_lo    = rd_head.lo;
        rd_hi    = rd_head.hi;
        rd_seq   = rd_head.seq;
    end
endmodule

// File: rtl/fetch_unpack_chk.sv
module fetch_unpack_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2,
    parameter int DEPTH     = 12,
    parameter int CNT_W     = 4
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             rsp_valid,
    input logic                             rsp_ready,
    input logic [SLOT_W-1:0]                rsp_slot,
    input logic                             len_bit,
    input logic                             rsp_last,
    input logic                             in_rsp,
    input logic [NUM_SLOTS-1:0][CNT_W-1:0]  slot_cnt,
    input logic                             done_valid,
    input logic                             err_occ,
    input logic                             err_drop,
    input logic                             err_trunc
);
    logic             accept;
    logic [CNT_W-1:0] tgt_cnt;

    assign accept  = rsp_valid && rsp_ready;
    assign tgt_cnt = slot_cnt[rsp_slot];

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (!done_valid && !err_occ && !err_drop && !err_trunc));

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> $past(accept && rsp_last));

    // R8
    trunc_source_chk: assert property (@(posedge clk) disable iff (rst)
        err_trunc |-> $past(accept && rsp_last && len_bit));

    // R6
    drop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        err_drop |-> $past(accept && !in_rsp && (tgt_cnt != '0)));

    // R7
    occ_limit_chk: assert property (@(posedge clk) disable iff (rst)
        err_occ |-> $past(accept && !in_rsp && (tgt_cnt > CNT_W'(4))));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_bound
        // R10
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            slot_cnt[s] <= CNT_W'(DEPTH));
    end
endmodule

bind fetch_unpack fetch_unpack_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .DEPTH     (DEPTH),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_slot   (rsp_slot),
    .len_bit    (rsp_word[31]),
    .rsp_last   (rsp_last),
    .in_rsp     (rsp_in_prog),
    .slot_cnt   (slot_cnt),
    .done_valid (done_valid),
    .err_occ    (err_occ),
    .err_drop   (err_drop),
    .err_trunc  (err_trunc)
);

// File: tb/fetch_unpack_bench.sv
module fetch_unpack_bench;
    localparam int NS  = 4;
    localparam int CW  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [1:0]  rsp_slot = '0;
    logic [31:0] rsp_word = '0;
    logic        rsp_last = 1'b0;
    logic        drop_valid = 1'b0;
    logic [1:0]  drop_slot = '0;
    logic [1:0]  rd_slot = '0;
    logic        rd_pop = 1'b0;
    logic        rd_valid, rd_wide;
    logic [31:0] rd_lo, rd_hi;
    logic [15:0] rd_seq;
    logic [CW-1:0] rd_count;
    logic        done_valid, err_occ, err_drop, err_trunc;
    logic [1:0]  done_slot;

    fetch_unpack u_fetch_unpack (
        .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_slot(rsp_slot), .rsp_word(rsp_word), .rsp_last(rsp_last),
        .drop_valid(drop_valid), .drop_slot(drop_slot), .rd_slot(rd_slot),
        .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_wide(rd_wide), .rd_lo(rd_lo),
        .rd_hi(rd_hi), .rd_seq(rd_seq), .rd_count(rd_count),
        .done_valid(done_valid), .done_slot(done_slot), .err_occ(err_occ),
        .err_drop(err_drop), .err_trunc(err_trunc)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model
    bit          m_wide [NS][64];
    bit [31:0]   m_lo   [NS][64];
    bit [31:0]   m_hi   [NS][64];
    int          m_seq  [NS][64];
    int          qh [NS];
    int          qt [NS];
    bit          m_drop [NS];
    int          seq_model = 0;
    bit [31:0]   resp_w [16];
    int          e_occ, e_drop, e_trunc;

    int obs_done = 0, obs_occ = 0, obs_drop = 0, obs_trunc = 0;
    int obs_done_slot = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done_valid) begin obs_done++; obs_done_slot = int'(done_slot); end
            if (err_occ)   obs_occ++;
            if (err_drop)  obs_drop++;
            if (err_trunc) obs_trunc++;
        end
    end

    task automatic check_eq(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void model_push(int s, bit w, bit [31:0] lo, bit [31:0] hi);
        m_wide[s][qt[s] & 63] = w;
        m_lo[s][qt[s] & 63]   = lo;
        m_hi[s][qt[s] & 63]   = hi;
        m_seq[s][qt[s] & 63]  = seq_model & 16'hffff;
        seq_model++;
        qt[s]++;
    endfunction

    function automatic void model_rsp(int s, int n);
        int i;
        bit dr;
        e_occ   = ((qt[s] - qh[s]) > 4) ? 1 : 0;
        dr      = m_drop[s];
        e_drop  = (dr && (qt[s] != qh[s])) ? 1 : 0;
        e_trunc = 0;
        m_drop[s] = 1'b0;
        if (!dr) begin
            i = 0;
            while (i < n) begin
                if (resp_w[i][31]) begin
                    if (i == n - 1) begin e_trunc = 1; i++; end
                    else begin model_push(s, 1'b1, resp_w[i], resp_w[i+1]); i += 2; end
                end else begin
                    model_push(s, 1'b0, resp_w[i], 32'h0);
                    i++;
                end
            end
        end
    endfunction

    task automatic set_drop(int s);
        @(negedge clk);
        drop_valid = 1'b1;
        drop_slot  = 2'(s);
        @(negedge clk);
        drop_valid = 1'b0;
        m_drop[s]  = 1'b1;
    endtask

    task automatic send_rsp(int s, int n);
        model_rsp(s, n);
        obs_done = 0; obs_occ = 0; obs_drop = 0; obs_trunc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rsp_valid = 1'b1;
            rsp_slot  = 2'(s);
            rsp_word  = resp_w[i];
            rsp_last  = (i == n - 1);
            #1;
            while (!rsp_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_last  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_eq("R9", "done pulses", obs_done, 1);
        check_eq("R9", "done slot", obs_done_slot, s);
        check_eq("R7", "occupancy error", obs_occ, e_occ);
        check_eq("R6", "drop error", obs_drop, e_drop);
        check_eq("R8", "truncation error", obs_trunc, e_trunc);
    endtask

    // R2 R3 R4 R11: head of slot compared with model in order
    task automatic pop_check(int s);
        int k;
        @(negedge clk);
        rd_slot = 2'(s);
        #1;
        k = qh[s] & 63;
        check_eq("R11", "rd_valid", rd_valid, 1);
        check_eq("R3", "rd_wide", rd_wide, m_wide[s][k]);
        check_eq("R2", "rd_lo", rd_lo, m_lo[s][k]);
        check_eq("R3", "rd_hi", rd_hi, m_hi[s][k]);
        check_eq("R4", "rd_seq", rd_seq, m_seq[s][k]);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        qh[s]++;
    endtask

    task automatic count_check(string req, int s);
        @(negedge clk);
        rd_slot = 2'(s);
        #1;
        check_eq(req, "rd_count", rd_count, qt[s] - qh[s]);
    endtask

    task automatic drain_check(int s);
        while (qt[s] > qh[s]) pop_check(s);
        @(negedge clk);
        rd_slot = 2'(s);
        #1;
        check_eq("R11", "empty after drain", rd_valid, 0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int s = 0; s < NS; s++) begin qh[s] = 0; qt[s] = 0; m_drop[s] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int s = 0; s < NS; s++) begin
            @(negedge clk);
            rd_slot = 2'(s);
            #1;
            check_eq("R1", "rd_count", rd_count, 0);
            check_eq("R1", "rd_valid", rd_valid, 0);
        end
        check_eq("R1", "pulses", {done_valid, err_occ, err_drop, err_trunc}, 0);

        // R2: narrow words only
        resp_w[0] = 32'h0000_1111; resp_w[1] = 32'h7fff_0002; resp_w[2] = 32'h1234_5678;
        send_rsp(1, 3);
        count_check("R2", 1);
        drain_check(1);

        // R3: mixed narrow and wide, second word with bit 31 set
        resp_w[0] = 32'h0000_00aa; resp_w[1] = 32'h8000_0bbb; resp_w[2] = 32'hffff_ffff;
        resp_w[3] = 32'h0000_0ccc;
        send_rsp(2, 4);
        count_check("R3", 2);
        drain_check(2);

        // R5: dropped line writes nothing, mark cleared
        set_drop(0);
        resp_w[0] = 32'h1; resp_w[1] = 32'h2; resp_w[2] = 32'h8000_0003; resp_w[3] = 32'h4;
        send_rsp(0, 4);
        count_check("R5", 0);
        resp_w[0] = 32'h5; resp_w[1] = 32'h6;
        send_rsp(0, 2);
        count_check("R5", 0);
        drain_check(0);

        // R6: drop on a non-empty buffer
        resp_w[0] = 32'h10; resp_w[1] = 32'h11;
        send_rsp(3, 2);
        set_drop(3);
        resp_w[0] = 32'h12; resp_w[1] = 32'h13; resp_w[2] = 32'h14;
        send_rsp(3, 3);
        count_check("R6", 3);
        drain_check(3);

        // R8: wide instruction cut off at the end of the line
        resp_w[0] = 32'h20; resp_w[1] = 32'h8000_0021;
        send_rsp(1, 2);
        count_check("R8", 1);
        drain_check(1);

        // R7: line arriving over the fill threshold
        for (int i = 0; i < 6; i++) resp_w[i] = 32'h30 + 32'(i);
        send_rsp(1, 6);
        resp_w[0] = 32'h40; resp_w[1] = 32'h41;
        send_rsp(1, 2);
        count_check("R7", 1);
        drain_check(1);

        // R10: stall on a full buffer, release by popping
        for (int i = 0; i < 8; i++) resp_w[i] = 32'h50 + 32'(i);
        send_rsp(2, 8);
        for (int i = 0; i < 8; i++) resp_w[i] = 32'h60 + 32'(i);
        fork
            send_rsp(2, 8);
            begin
                repeat (30) @(negedge clk);
                rd_slot = 2'd2;
                #1;
                check_eq("R10", "count at stall", rd_count, 12);
                check_eq("R10", "ready at stall", rsp_ready, 0);
                for (int i = 0; i < 4; i++) pop_check(2);
            end
        join
        count_check("R10", 2);
        drain_check(2);

        // random lines across slots
        for (int k = 0; k < 60; k++) begin
            int s, n;
            s = int'($urandom % NS);
            n = 1 + int'($urandom % 8);
            for (int i = 0; i < n; i++) resp_w[i] = $urandom;
            if (($urandom % 6) == 0) set_drop(s);
            send_rsp(s, n);
            count_check("R4", s);
            if ((qt[s] - qh[s]) > 4 || ($urandom % 2) == 1) drain_check(s);
        end
        for (int s = 0; s < NS; s++) drain_check(s);

        summary();
    end
endmodule